// File: doc/BRIEF.md
# Command Strobe Dispatcher

This block sits between an SPI front-end and a radio control state machine. The front-end hands it one decoded six-bit strobe code at a time, qualified by a valid flag. The dispatcher decides when each strobe takes effect. It then raises a single-cycle execute pulse on the output bit assigned to that strobe. Most strobes fire in the cycle after they arrive. Three of them are held until the chip-select line returns high: power-down, wake-on-radio and oscillator-off.

An idle strobe fires at once and discards everything queued behind it. Every later strobe except another idle is refused until the controller reports that it has reached idle. A reset strobe fires at once and raises a busy flag for a fixed number of cycles. The front-end drives this flag onto its serial data-out line. While the flag is high, incoming strobes are refused. When it drops, all held and pending strobe state is cleared.

Top module: `strobe_dispatch`

## Requirements
- R1: After reset, `exec_pulse` is all zero and `rst_busy` is low.
- R2: An accepted immediate strobe with code C raises only `exec_pulse[C-0x30]`, in the cycle after the strobe is presented. The immediate codes are 0x30, 0x31, 0x33, 0x34, 0x35, 0x36 and 0x3A to 0x3D.
- R3: The deferred codes are 0x32, 0x38 and 0x39. They raise no pulse on arrival. Their bit pulses in the cycle after `cs_n` is first sampled high following a low sample.
- R4: Only one deferred strobe is held. A later deferred strobe within the same chip-select low period replaces the earlier one, and only the later one fires.
- R5: Code 0x37 and all codes outside 0x30 to 0x3D produce no pulse and change no state. `exec_pulse[7]` never rises.
- R6: The idle strobe 0x36 pulses bit 6 and discards any held deferred strobe, so the next chip-select rise fires nothing.
- R7: After an idle strobe, and while `ctrl_idle` is low, every strobe other than 0x36 is ignored. This includes deferred strobes and the reset strobe. Once `ctrl_idle` is high, strobes are accepted again.
- R8: The reset strobe 0x30 pulses bit 0. In the same cycle, `rst_busy` rises and stays high for exactly RESET_CYCLES cycles.
- R9: Strobes presented while `rst_busy` is high are ignored. A deferred strobe held before the reset strobe never fires.
- R10: Every execute pulse lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stb_valid | input | 1 | Strobe code is valid this cycle |
| stb_code | input | 6 | Strobe register address |
| cs_n | input | 1 | Chip-select level, active low |
| ctrl_idle | input | 1 | Radio controller has reached idle |
| exec_pulse | output | 14 | Execute pulses, bit index = code - 0x30 |
| rst_busy | output | 1 | Reset in progress, driven onto data out |

## Verification
The hardest state to reach is the flush window: an idle strobe has been accepted but the controller has not yet reported idle. Only there are ordinary, deferred and reset strobes refused while a repeated idle still passes. The bench holds `ctrl_idle` low, issues an idle strobe and then feeds immediate, deferred and reset codes followed by a chip-select rise, before it releases `ctrl_idle`. A full sweep over all 64 codes, with `ctrl_idle` high, covers decoding, deferral and the busy window.

// File: rtl/strobe_pkg.sv
package strobe_pkg;
  localparam int CODE_W     = 6;
  localparam int SLOT_N     = 14;
  localparam int BASE_CODE  = 48;
  localparam int IDX_RESET  = 0;
  localparam int IDX_OSCOFF = 2;
  localparam int IDX_IDLE   = 6;
  localparam int IDX_HOLE   = 7;
  localparam int IDX_WAKE   = 8;
  localparam int IDX_PDOWN  = 9;

  typedef logic [SLOT_N-1:0] slot_vec_t;
  typedef logic [CODE_W-1:0] code_t;

  function automatic bit slot_is_deferred(int idx);
    return (idx == IDX_OSCOFF) || (idx == IDX_WAKE) || (idx == IDX_PDOWN);
  endfunction
endpackage

// File: rtl/strobe_decode.sv
module strobe_decode
  import strobe_pkg::*;
(
  input  code_t     code,
  output slot_vec_t hit,
  output logic      known,
  output logic      deferred,
  output logic      is_idle,
  output logic      is_reset
);
  slot_vec_t defer_mask;

  for (genvar i = 0; i < SLOT_N; i++) begin : g_slot
    if (i == IDX_HOLE) begin : g_hole
      assign hit[i]        = 1'b0;
      assign defer_mask[i] = 1'b0;
    end else begin : g_real
      assign hit[i]        = (code == CODE_W'(BASE_CODE + i));
      assign defer_mask[i] = slot_is_deferred(i) ? 1'b1 : 1'b0;
    end
  end

  always_comb begin
    known    = |hit;
    deferred = |(hit & defer_mask);
    is_idle  = hit[IDX_IDLE];
    is_reset = hit[IDX_RESET];
  end
endmodule

// File: rtl/defer_hold.sv
module defer_hold
  import strobe_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cs_n,
  input  logic      load,
  input  slot_vec_t load_vec,
  input  logic      clear,
  output slot_vec_t fire_vec
);
  slot_vec_t held_q, held_n, cand;
  logic      cs_q, cs_rise;

  always_comb begin
    cs_rise  = cs_n & ~cs_q;
    cand     = load ? load_vec : held_q;
    fire_vec = (cs_rise && !clear) ? cand : '0;
    held_n   = held_q;
    if (clear || cs_rise) held_n = '0;
    else if (load)        held_n = load_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= '0;
      cs_q   <= 1'b1;
    end else begin
      held_q <= held_n;
      cs_q   <= cs_n;
    end
  end
endmodule

// File: rtl/busy_timer.sv
module busy_timer #(
  parameter int CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CNT_W = $clog2(CYCLES + 1);

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             busy_q, busy_n;
  logic             cnt_en;

  always_comb begin
    done   = busy_q && (cnt_q == '0);
    cnt_en = start || busy_q;
    busy_n = busy_q;
    cnt_n  = cnt_q;
    if (start) begin
      busy_n = 1'b1;
      cnt_n  = CNT_W'(CYCLES - 1);
    end else if (busy_q) begin
      if (done) busy_n = 1'b0;
      else      cnt_n  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (cnt_en) begin
      busy_q <= busy_n;
      cnt_q  <= cnt_n;
    end
  end

  assign busy = busy_q;
endmodule

// File: rtl/strobe_dispatch.sv
module strobe_dispatch
  import strobe_pkg::*;
#(
  parameter int RESET_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb_valid,
  input  logic [5:0]        stb_code,
  input  logic              cs_n,
  input  logic              ctrl_idle,
  output logic [SLOT_N-1:0] exec_pulse,
  output logic              rst_busy
);
  slot_vec_t hit, imm_vec, fire_vec, exec_q, exec_n;
  logic      known, deferred, is_idle, is_reset;
  logic      busy, busy_done;
  logic      flush_q, flush_n, flush_gate;
  logic      accept, hold_load, hold_clear;

  strobe_decode u_dec (
    .code     (stb_code),
    .hit      (hit),
    .known    (known),
    .deferred (deferred),
    .is_idle  (is_idle),
    .is_reset (is_reset)
  );

  always_comb begin
    flush_gate = flush_q && !ctrl_idle;
    accept     = stb_valid && known && !busy && (!flush_gate || is_idle);
    hold_load  = accept && deferred;
    hold_clear = (accept && (is_idle || is_reset)) || busy_done;
    imm_vec    = (accept && !deferred) ? hit : '0;
    exec_n     = imm_vec | fire_vec;
    flush_n    = flush_q;
    if (busy_done)              flush_n = 1'b0;
    else if (accept && is_idle) flush_n = 1'b1;
    else if (ctrl_idle)         flush_n = 1'b0;
  end

  defer_hold u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .load     (hold_load),
    .load_vec (hit),
    .clear    (hold_clear),
    .fire_vec (fire_vec)
  );

  busy_timer #(.CYCLES(RESET_CYCLES)) u_busy (
    .clk   (clk),
    .rst_n (rst_n),
    .start (accept && is_reset),
    .busy  (busy),
    .done  (busy_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exec_q  <= '0;
      flush_q <= 1'b0;
    end else begin
      exec_q  <= exec_n;
      flush_q <= flush_n;
    end
  end

  assign exec_pulse = exec_q;
  assign rst_busy   = busy;
endmodule

// File: rtl/strobe_dispatch_chk.sv
module strobe_dispatch_chk #(
  parameter int RESET_CYCLES = 64
) (
  input logic        clk,
  input logic        rst_n,
  input logic        stb_valid,
  input logic [5:0]  stb_code,
  input logic        cs_n,
  input logic [13:0] exec_pulse,
  input logic        rst_busy
);
  logic [31:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        run_q <= '0;
    else if (rst_busy) run_q <= run_q + 1;
    else               run_q <= '0;
  end

  assert_reset_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_busy) |-> exec_pulse[0]);

  assert_busy_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_busy) |-> run_q == RESET_CYCLES);

  assert_busy_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_busy |-> run_q < RESET_CYCLES);

  assert_quiet_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_busy) |-> exec_pulse == '0);

  assert_defer_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_pulse[2] || exec_pulse[8] || exec_pulse[9]) |-> ($past(cs_n) && !$past(cs_n, 2)));

  assert_idle_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
    exec_pulse[6] |-> ($past(stb_valid) && $past(stb_code) == 6'h36));

  assert_rx_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
    exec_pulse[4] |-> ($past(stb_valid) && $past(stb_code) == 6'h34));

  assert_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    exec_pulse[4] |=> !exec_pulse[4]);

  assert_hole_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_valid && stb_code == 6'h37) |=> !exec_pulse[7]);
endmodule

bind strobe_dispatch strobe_dispatch_chk #(.RESET_CYCLES(RESET_CYCLES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .stb_valid  (stb_valid),
  .stb_code   (stb_code),
  .cs_n       (cs_n),
  .exec_pulse (exec_pulse),
  .rst_busy   (rst_busy)
);

// File: tb/strobe_dispatch_tb.sv
module strobe_dispatch_tb;
  localparam int CLK_PERIOD = 10;
  localparam int RST_CYC    = 5;

  logic        clk, rst_n, stb_valid, cs_n, ctrl_idle;
  logic [5:0]  stb_code;
  logic [13:0] exec_pulse;
  logic        rst_busy;
  int          n_tot, n_fail;

  strobe_dispatch #(.RESET_CYCLES(RST_CYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .stb_valid(stb_valid), .stb_code(stb_code),
    .cs_n(cs_n), .ctrl_idle(ctrl_idle), .exec_pulse(exec_pulse), .rst_busy(rst_busy)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int slot_of(int code);
    if (code < 48 || code > 61 || code == 55) return -1;
    return code - 48;
  endfunction

  function automatic bit is_def(int code);
    int s = slot_of(code);
    return (s == 2) || (s == 8) || (s == 9);
  endfunction

  function automatic logic [13:0] bitv(int s);
    return (s < 0) ? 14'd0 : (14'd1 << s);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tot++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic strobe(input int code, input logic [13:0] exp, input string req);
    @(negedge clk); stb_valid = 1'b1; stb_code = 6'(code);
    @(negedge clk); stb_valid = 1'b0;
    check(exec_pulse == exp, req, 32'(exec_pulse), 32'(exp));
  endtask

  task automatic quiet(input string req);
    @(negedge clk);
    check(exec_pulse == 14'd0, req, 32'(exec_pulse), 0);
  endtask

  task automatic rise(input logic [13:0] exp, input string req);
    @(negedge clk); cs_n = 1'b1;
    @(negedge clk);
    check(exec_pulse == exp, req, 32'(exec_pulse), 32'(exp));
    cs_n = 1'b0;
  endtask

  task automatic busy_run(output int n);
    n = 0;
    while (rst_busy && n < 100) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tot++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
    $finish;
  end

  initial begin
    int n;
    n_tot = 0; n_fail = 0;
    rst_n = 1'b0; stb_valid = 1'b0; stb_code = '0; cs_n = 1'b1; ctrl_idle = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(exec_pulse == 0 && !rst_busy, "R1", {17'd0, rst_busy, exec_pulse}, 0);
    cs_n = 1'b0;
    @(negedge clk);

    // Sweep all 64 codes: R2, R3, R5, R8, R10
    for (int c = 0; c < 64; c++) begin
      if (c == 48) begin
        strobe(c, bitv(0), "R8");
        check(rst_busy, "R8", 32'(rst_busy), 1);
        busy_run(n);
        check(n == RST_CYC, "R8", n, RST_CYC);
      end else begin
        strobe(c, is_def(c) ? 14'd0 : bitv(slot_of(c)),
               slot_of(c) < 0 ? "R5" : (is_def(c) ? "R3" : "R2"));
        quiet("R10");
      end
      rise(is_def(c) ? bitv(slot_of(c)) : 14'd0, is_def(c) ? "R3" : "R5");
    end

    // R4: later deferred replaces earlier
    strobe(56, 0, "R4");
    strobe(57, 0, "R4");
    rise(bitv(9), "R4");
    strobe(50, 0, "R4");
    repeat (3) @(negedge clk);
    rise(bitv(2), "R4");

    // R6: idle discards held deferred
    strobe(56, 0, "R6");
    strobe(54, bitv(6), "R6");
    rise(0, "R6");

    // R7: flush window
    ctrl_idle = 1'b0;
    strobe(54, bitv(6), "R7");
    strobe(52, 0, "R7");
    strobe(57, 0, "R7");
    strobe(48, 0, "R7");
    check(!rst_busy, "R7", 32'(rst_busy), 0);
    rise(0, "R7");
    strobe(54, bitv(6), "R7");
    ctrl_idle = 1'b1;
    @(negedge clk);
    strobe(52, bitv(4), "R7");

    // R9: ignored while busy; held deferred dropped
    strobe(56, 0, "R9");
    strobe(48, bitv(0), "R9");
    strobe(52, 0, "R9");
    strobe(54, 0, "R9");
    busy_run(n);
    rise(0, "R9");
    strobe(52, bitv(4), "R9");
    quiet("R10");

    $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
    $finish;
  end
endmodule